// File: doc/BRIEF.md
# Calibration and Resynchronisation Sequencer for a Decimating ADC

This block times the digital control events around an oversampling converter core with a decimation filter. It watches three control inputs: a calibration request, an active-low resynchronise line and a polarity-mode select. It runs one master-clock counter through four phases: filter settling, calibration, post-calibration lag and normal running. From these phases it drives a result-valid flag, a one-cycle ready strobe once per output word, and two flags that show whether calibration or the lag after it is in progress.

When the resynchronise line is sampled low, it clears the valid flag and restarts the filter settle window. When a calibration request has been qualified, the block runs a fixed-length calibration window. The length of that window depends on the polarity mode, which is captured when the request is accepted. The computation of the offset and gain corrections is done elsewhere. Every delay is a parameter. The defaults are 8192-cycle long blocks, 512-cycle short blocks, a 64-cycle lag and a 64-cycle word period.

Top module: `adc_cal_seq`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it, `data_valid`, `drdy`, `cal_busy` and `cal_lag` are all 0, and the block is in the settle window.
- R2: When `sync_n` is sampled 0 at a rising edge, `data_valid`, `drdy`, `cal_busy` and `cal_lag` are 0 from the next cycle. They stay 0 for as long as `sync_n` stays low.
- R3: The last rising edge at which `rst` is high or `sync_n` is low is edge 0. With no calibration in between, `data_valid` becomes 1 after exactly LONG_CYC+LAG_CYC further edges (8256 by default).
- R4: A calibration request is accepted only when `cal_req` is sampled 1 at two consecutive rising edges and was 0 at the edge before them. A request that is high for a single edge has no effect.
- R5: With `uni_mode`=1 (unipolar), `cal_busy` is high for exactly 3*LONG_CYC+2*SHORT_CYC cycles, starting in the cycle after the accepting edge.
- R6: With `uni_mode`=0 (bipolar), `cal_busy` is high for exactly 4*LONG_CYC+3*SHORT_CYC cycles.
- R7: When `cal_busy` falls, `cal_lag` is high for exactly LAG_CYC cycles. `data_valid` rises in the cycle after that. `data_valid` is 0 throughout calibration and lag.
- R8: `drdy` is a one-cycle pulse. It is high in the first cycle of `data_valid`, then every DRDY_PERIOD cycles while `data_valid` stays 1, and never when `data_valid` is 0.
- R9: A calibration request that qualifies while `cal_busy` or `cal_lag` is high is ignored. The running calibration keeps its length and its lag.
- R10: If `sync_n` is sampled low during calibration or lag, the calibration is abandoned. The settle window of R3 then applies from the last low sample.
- R11: `uni_mode` is captured at the accepting edge. Changing it later in the calibration does not change the length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_req | input | 1 | Calibration request, active high |
| sync_n | input | 1 | Resynchronise the filter, active low |
| uni_mode | input | 1 | 1 = unipolar calibration, 0 = bipolar |
| data_valid | output | 1 | Conversion results are valid |
| drdy | output | 1 | One-cycle pulse per output word |
| cal_busy | output | 1 | Calibration window in progress |
| cal_lag | output | 1 | Lag between calibration end and first valid word |

## Verification
The hardest states to reach from the ports are the ones where a second event lands inside a window that is tens of thousands of cycles long. Examples are a qualified request during calibration or during the lag, a mode flip halfway through, and a resynchronise that cuts a calibration short. The bench builds the block with short block lengths so that each window lasts only hundreds of cycles. Inside the loop that counts the busy and lag cycles, it injects the disturbing stimulus at chosen cycle numbers. It then compares each measured phase length against the lengths worked out from the requirements.

// File: rtl/adc_cal_seq_pkg.sv
package adc_cal_seq_pkg;
  typedef enum logic [1:0] {
    PH_SETTLE = 2'd0,
    PH_CAL    = 2'd1,
    PH_LAG    = 2'd2,
    PH_RUN    = 2'd3
  } seq_phase_e;
endpackage

// File: rtl/adc_cal_seq_reqflt.sv
// Qualifies a calibration request: high on two consecutive edges after being low.
module adc_cal_seq_reqflt (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic accept
);
  logic req_d1;
  logic req_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d1 <= 1'b0;
      req_d2 <= 1'b0;
    end else begin
      req_d1 <= req;
      req_d2 <= req_d1;
    end
  end

  assign accept = req & req_d1 & ~req_d2;
endmodule

// File: rtl/adc_cal_seq_lensel.sv
// Picks the terminal count (length minus one) of the calibration window.
module adc_cal_seq_lensel #(
  parameter int LONG_CYC  = 8192,
  parameter int SHORT_CYC = 512,
  parameter int CW        = 16
) (
  input  logic          uni,
  output logic [CW-1:0] last_idx
);
  localparam int UNI_LEN = 3 * LONG_CYC + 2 * SHORT_CYC;
  localparam int BIP_LEN = 4 * LONG_CYC + 3 * SHORT_CYC;
  localparam logic [CW-1:0] UNI_LAST = CW'(UNI_LEN - 1);
  localparam logic [CW-1:0] BIP_LAST = CW'(BIP_LEN - 1);

  assign last_idx = uni ? UNI_LAST : BIP_LAST;
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_cal_seq_pkg::*;
#(
  parameter int LONG_CYC    = 8192,
  parameter int SHORT_CYC   = 512,
  parameter int LAG_CYC     = 64,
  parameter int DRDY_PERIOD = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic cal_req,
  input  logic sync_n,
  input  logic uni_mode,
  output logic data_valid,
  output logic drdy,
  output logic cal_busy,
  output logic cal_lag
);
  localparam int BIP_LEN    = 4 * LONG_CYC + 3 * SHORT_CYC;
  localparam int SETTLE_LEN = LONG_CYC + LAG_CYC;
  localparam int MAX_LEN    = (BIP_LEN > SETTLE_LEN) ? BIP_LEN : SETTLE_LEN;
  localparam int CW         = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_LEN - 1);
  localparam logic [CW-1:0] LAG_LAST    = CW'(LAG_CYC - 1);
  localparam logic [CW-1:0] WORD_LAST   = CW'(DRDY_PERIOD - 1);
  localparam logic [CW-1:0] ONE         = CW'(1);

  seq_phase_e    phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cal_last_q;
  logic [CW-1:0] cal_last_sel;
  logic          req_ok;

  adc_cal_seq_reqflt u_reqflt (
    .clk    (clk),
    .rst    (rst),
    .req    (cal_req),
    .accept (req_ok)
  );

  adc_cal_seq_lensel #(
    .LONG_CYC  (LONG_CYC),
    .SHORT_CYC (SHORT_CYC),
    .CW        (CW)
  ) u_lensel (
    .uni      (uni_mode),
    .last_idx (cal_last_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_SETTLE;
      cnt        <= '0;
      cal_last_q <= '0;
    end else if (!sync_n) begin
      phase <= PH_SETTLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_SETTLE: begin
          if (req_ok) begin
            phase      <= PH_CAL;
            cnt        <= '0;
            cal_last_q <= cal_last_sel;
          end else if (cnt == SETTLE_LAST) begin
            phase <= PH_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        PH_CAL: begin
          if (cnt == cal_last_q) begin
            phase <= PH_LAG;
            cnt   <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        PH_LAG: begin
          if (cnt == LAG_LAST) begin
            phase <= PH_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        PH_RUN: begin
          if (req_ok) begin
            phase      <= PH_CAL;
            cnt        <= '0;
            cal_last_q <= cal_last_sel;
          end else if (cnt == WORD_LAST) begin
            cnt <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        default: begin
          phase <= PH_SETTLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  // Outputs decode registered state only; no input reaches them combinationally.
  assign data_valid = (phase == PH_RUN);
  assign drdy       = (phase == PH_RUN) && (cnt == '0);
  assign cal_busy   = (phase == PH_CAL);
  assign cal_lag    = (phase == PH_LAG);
endmodule

// File: rtl/adc_cal_seq_chk.sv
module adc_cal_seq_chk (
  input logic clk,
  input logic rst,
  input logic cal_req,
  input logic sync_n,
  input logic data_valid,
  input logic drdy,
  input logic cal_busy,
  input logic cal_lag
);
  assert_sync_clears_R2: assert property (@(posedge clk) disable iff (rst)
    !sync_n |=> (!data_valid && !drdy && !cal_busy && !cal_lag));

  assert_accept_two_edges_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_busy) |-> ($past(cal_req) && $past(cal_req, 2)));

  assert_lag_after_cal_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(cal_busy) |-> (cal_lag || !$past(sync_n) || $past(rst)));

  assert_valid_after_lag_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(cal_lag) && $past(sync_n) && !$past(rst)) |-> data_valid);

  assert_drdy_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    drdy |-> data_valid);

  assert_drdy_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    drdy |=> !drdy);

  assert_first_word_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid) |-> drdy);

  assert_no_restart_from_lag_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_busy) |-> !$past(cal_lag));
endmodule

bind adc_cal_seq adc_cal_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cal_req    (cal_req),
  .sync_n     (sync_n),
  .data_valid (data_valid),
  .drdy       (drdy),
  .cal_busy   (cal_busy),
  .cal_lag    (cal_lag)
);

// File: tb/adc_cal_seq_tb.sv
module adc_cal_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_C     = 256;
  localparam int SHORT_C    = 32;
  localparam int LAG_C      = 16;
  localparam int WORD_C     = 16;
  localparam int UNI_LEN    = 3 * LONG_C + 2 * SHORT_C;
  localparam int BIP_LEN    = 4 * LONG_C + 3 * SHORT_C;
  localparam int SETTLE_LEN = LONG_C + LAG_C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_req = 1'b0;
  logic sync_n = 1'b1;
  logic uni_mode = 1'b1;
  logic data_valid, drdy, cal_busy, cal_lag;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_cal_seq #(
    .LONG_CYC    (LONG_C),
    .SHORT_CYC   (SHORT_C),
    .LAG_CYC     (LAG_C),
    .DRDY_PERIOD (WORD_C)
  ) dut_i (
    .clk        (clk),
    .rst        (rst),
    .cal_req    (cal_req),
    .sync_n     (sync_n),
    .uni_mode   (uni_mode),
    .data_valid (data_valid),
    .drdy       (drdy),
    .cal_busy   (cal_busy),
    .cal_lag    (cal_lag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_to_valid(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!data_valid && k < 5000);
  endtask

  task automatic t_reset();
    int k;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({data_valid, drdy, cal_busy, cal_lag} == 4'b0, "R1 outputs in reset",
          {data_valid, drdy, cal_busy, cal_lag}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({data_valid, drdy, cal_busy, cal_lag} == 4'b0, "R1 outputs after reset",
          {data_valid, drdy, cal_busy, cal_lag}, 0);
    k = 1;
    while (!data_valid && k < 5000) begin
      @(negedge clk);
      k++;
    end
    check(k == SETTLE_LEN, "R3 settle length after reset", k, SETTLE_LEN);
  endtask

  task automatic t_drdy();
    int bad = 0;
    check(drdy == 1'b1, "R8 strobe in first valid cycle", drdy, 1);
    for (int i = 1; i <= 3 * WORD_C; i++) begin
      @(negedge clk);
      if (drdy != ((i % WORD_C) == 0)) bad++;
    end
    check(bad == 0, "R8 strobe period mismatches", bad, 0);
  endtask

  // Runs one calibration; disturb: 0 none, 1 extra requests (R9), 2 mode flip (R11).
  task automatic t_cal(input bit uni, input int exp_len, input int disturb, input string tag);
    int busy_n, lag_n, valid_seen;
    uni_mode = uni;
    cal_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(cal_busy == 1'b1, {tag, " accepted after two edges"}, cal_busy, 1);
    cal_req = 1'b0;
    busy_n = 1;
    valid_seen = 0;
    forever begin
      @(negedge clk);
      if (!cal_busy) break;
      busy_n++;
      if (data_valid) valid_seen++;
      if (disturb == 1 && busy_n == 10) cal_req = 1'b1;
      if (disturb == 1 && busy_n == 14) cal_req = 1'b0;
      if (disturb == 2 && busy_n == 20) uni_mode = ~uni_mode;
    end
    check(busy_n == exp_len, {tag, " calibration length"}, busy_n, exp_len);
    check(valid_seen == 0, "R7 valid low during calibration", valid_seen, 0);
    check(cal_lag == 1'b1, "R7 lag follows calibration", cal_lag, 1);
    lag_n = 1;
    forever begin
      @(negedge clk);
      if (!cal_lag) break;
      lag_n++;
      if (disturb == 1 && lag_n == 2) cal_req = 1'b1;
      if (disturb == 1 && lag_n == 5) cal_req = 1'b0;
    end
    check(lag_n == LAG_C, "R7 lag length", lag_n, LAG_C);
    check(data_valid && drdy && !cal_busy, "R7 valid with strobe after lag",
          {data_valid, drdy, cal_busy}, 3'b110);
  endtask

  task automatic t_short_pulse();
    int busy_seen = 0;
    int invalid_seen = 0;
    cal_req = 1'b1;
    @(negedge clk);
    cal_req = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (cal_busy) busy_seen++;
      if (!data_valid) invalid_seen++;
    end
    check(busy_seen == 0, "R4 single-edge request ignored", busy_seen, 0);
    check(invalid_seen == 0, "R4 valid kept after short pulse", invalid_seen, 0);
  endtask

  task automatic t_sync_run();
    int k;
    sync_n = 1'b0;
    @(negedge clk);
    check({data_valid, drdy} == 2'b00, "R2 sync clears valid", {data_valid, drdy}, 0);
    sync_n = 1'b1;
    count_to_valid(k);
    check(k == SETTLE_LEN, "R3 settle length after sync", k, SETTLE_LEN);
  endtask

  task automatic t_sync_abort();
    int k;
    int busy_seen = 0;
    uni_mode = 1'b1;
    cal_req = 1'b1;
    repeat (2) @(negedge clk);
    cal_req = 1'b0;
    repeat (20) @(negedge clk);
    check(cal_busy == 1'b1, "R10 calibration running", cal_busy, 1);
    sync_n = 1'b0;
    @(negedge clk);
    check({cal_busy, cal_lag, data_valid} == 3'b000, "R10 sync aborts calibration",
          {cal_busy, cal_lag, data_valid}, 0);
    repeat (3) begin
      @(negedge clk);
      if (cal_busy || data_valid) busy_seen++;
    end
    check(busy_seen == 0, "R2 held low keeps outputs clear", busy_seen, 0);
    sync_n = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (cal_busy) busy_seen++;
    end while (!data_valid && k < 5000);
    check(k == SETTLE_LEN, "R10 settle restarts after abort", k, SETTLE_LEN);
    check(busy_seen == 0, "R10 calibration not resumed", busy_seen, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_drdy();
    t_cal(1'b1, UNI_LEN, 0, "R5");
    t_cal(1'b0, BIP_LEN, 0, "R6");
    t_short_pulse();
    t_cal(1'b1, UNI_LEN, 1, "R9");
    t_cal(1'b0, BIP_LEN, 2, "R11");
    t_sync_run();
    t_sync_abort();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule